// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block runs the read and write cycles of a 16-bit processor with an asynchronous, strobe-based external bus. It advances one half-clock state per pulse of a state enable that runs at twice the processor clock rate. A cycle walks through eight states, S0 to S7. The function code, R/W, address, address strobe, upper and lower data strobes and the write data appear and go away at fixed states. The cycle stalls after S4 until the addressed device answers with an acknowledge or a bus-error termination.

A requester presents address, byte-lane selects, direction, function code and write data, and holds them with a valid flag. The block takes the request only when it is idle. When the cycle ends it gives a one-clock completion pulse, together with the latched read data or an error flag. A slow device costs one processor clock (two states) for each missed termination sample. A device that answers at once gets a cycle of exactly four processor clocks.

Top module: `abus_cycle_seq`

## Requirements
- R1: While reset is held and right after it, as_n, uds_n, lds_n and rw_n are high, a_oe, d_oe and done are low, and req_ready is high.
- R2: A request is accepted only on a clock where req_valid, st_en and req_ready are all high. The next state is S0. req_ready stays low from S0 until the cycle returns to idle, and a request held valid during a cycle is neither taken nor allowed to change the running cycle.
- R3: fc_out carries the accepted function code from S0 on and stays stable while as_n is low. rw_n is high in S0. a_oe rises in S1 with a_out equal to the accepted address, which stays stable until a_oe falls on entry to S7.
- R4: In a read, as_n is low from S2 through S6, including any wait states. uds_n is low in the same states when req_ub was 1, and lds_n likewise when req_lb was 1. All strobes are high in S7.
- R5: In a write, as_n is low from S2 through S6. rw_n is low and d_oe is high with d_out equal to the write data from S3 through S7. The selected data strobes go low in S3, one state after as_n, and rise together with as_n.
- R6: When dtack_n or berr_n is low at the enable that ends S4, the cycle goes straight to S5. The whole cycle from S0 to the end of S7 then takes eight enables, which is four processor clocks.
- R7: When neither termination is low at the enable that ends S4, two wait states follow. The termination is sampled again at the enable that ends the second wait state, and each further miss adds exactly two more states.
- R8: In a read ended by dtack_n alone, d_in is latched at the enable that ends S6 and appears on rdata from S7 on, with err low.
- R9: When berr_n is low at the termination sample, whether or not dtack_n is also low, the cycle still runs through S7. err is then 1 and rdata is 0.
- R10: done is high for exactly one clock, the clock after the enable that ends S7. States advance only on st_en, so the bus pins hold their values between enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_en | input | 1 | State enable, one pulse per half processor clock |
| req_valid | input | 1 | Request present |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_ub | input | 1 | Upper byte lane selected |
| req_lb | input | 1 | Lower byte lane selected |
| req_addr | input | AW | Word address |
| req_fc | input | FCW | Function code |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Sequencer idle, able to take a request |
| done | output | 1 | Cycle completed, one clock |
| rdata | output | DW | Read data latched at the end of S6 |
| err | output | 1 | Cycle ended by bus error |
| a_out | output | AW | Address bus value |
| a_oe | output | 1 | Address bus drive enable |
| fc_out | output | FCW | Function code pins |
| rw_n | output | 1 | High = read, low = write |
| as_n | output | 1 | Address strobe, active low |
| uds_n | output | 1 | Upper data strobe, active low |
| lds_n | output | 1 | Lower data strobe, active low |
| d_out | output | DW | Data bus value in writes |
| d_oe | output | 1 | Data bus drive enable |
| d_in | input | DW | Data bus value in reads |
| dtack_n | input | 1 | Data acknowledge, active low |
| berr_n | input | 1 | Bus error, active low |

## Verification
The bench uses the default widths: a 23-bit address, 16-bit data and a 3-bit function code. It runs one pass with the enable high on every clock, so each state can be checked pin by pin in its own clock. It also runs one pass with the enable high every third clock, which shows that the states stretch and the pins hold between enables. The wait counts go up to three pairs, and single-lane and both-lane selects are covered, so the length of a stall and the strobe masks can both be checked. Error-only and error-plus-acknowledge terminations show that the error takes priority.

// File: rtl/abus_seq_pkg.sv
// Shared types for the bus cycle sequencer.
// Assumes nothing beyond IEEE 1800-2017 enumerations.
package abus_seq_pkg;

    // Half-clock states of a bus cycle plus the two halves of a wait clock.
    typedef enum logic [3:0] {
        PH_IDLE,
        PH_S0, PH_S1, PH_S2, PH_S3, PH_S4, PH_S5, PH_S6, PH_S7,
        PH_W1, PH_W2
    } phase_t;

endpackage

// File: rtl/abus_seq_phase.sv
// State walker: advances one half-clock state per st_en pulse and stalls
// after S4 in whole-clock steps until a termination is seen.
// Assumes dtack_n and berr_n are already synchronous to clk.
module abus_seq_phase
    import abus_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   st_en,
    input  logic   req_valid,
    input  logic   dtack_n,
    input  logic   berr_n,
    output phase_t phase,
    output logic   accept,
    output logic   term_tick,
    output logic   s6_end,
    output logic   s7_end
);

    logic at_sample;
    logic term_seen;

    // Decision points and strobes for the other blocks.
    always_comb begin
        at_sample = (phase == PH_S4) || (phase == PH_W2);
        term_seen = !dtack_n || !berr_n;
        accept    = st_en && (phase == PH_IDLE) && req_valid;
        term_tick = st_en && at_sample && term_seen;
        s6_end    = st_en && (phase == PH_S6);
        s7_end    = st_en && (phase == PH_S7);
    end

    // State register, one step per enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else if (st_en) begin
            case (phase)
                PH_IDLE: if (req_valid) phase <= PH_S0;
                PH_S0:   phase <= PH_S1;
                PH_S1:   phase <= PH_S2;
                PH_S2:   phase <= PH_S3;
                PH_S3:   phase <= PH_S4;
                PH_S4:   phase <= term_seen ? PH_S5 : PH_W1;
                PH_W1:   phase <= PH_W2;
                PH_W2:   phase <= term_seen ? PH_S5 : PH_W1;
                PH_S5:   phase <= PH_S6;
                PH_S6:   phase <= PH_S7;
                PH_S7:   phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/abus_seq_capture.sv
// Holding registers: the accepted request, the termination kind, the read
// result and the one-clock completion pulse.
// Assumes accept, term_tick, s6_end and s7_end are single-clock strobes.
module abus_seq_capture #(
    parameter int AW  = 23,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           term_tick,
    input  logic           s6_end,
    input  logic           s7_end,
    input  logic           req_wr,
    input  logic           req_ub,
    input  logic           req_lb,
    input  logic [AW-1:0]  req_addr,
    input  logic [FCW-1:0] req_fc,
    input  logic [DW-1:0]  req_wdata,
    input  logic [DW-1:0]  d_in,
    input  logic           berr_n,
    output logic           wr_q,
    output logic           ub_q,
    output logic           lb_q,
    output logic [AW-1:0]  addr_q,
    output logic [FCW-1:0] fc_q,
    output logic [DW-1:0]  wdata_q,
    output logic [DW-1:0]  rdata,
    output logic           err,
    output logic           done
);

    logic berr_hit;

    // Latch the request fields when the cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            ub_q    <= 1'b0;
            lb_q    <= 1'b0;
            addr_q  <= '0;
            fc_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            wr_q    <= req_wr;
            ub_q    <= req_ub;
            lb_q    <= req_lb;
            addr_q  <= req_addr;
            fc_q    <= req_fc;
            wdata_q <= req_wdata;
        end
    end

    // Remember whether the termination was a bus error.
    always_ff @(posedge clk) begin
        if (!rst_n)         berr_hit <= 1'b0;
        else if (accept)    berr_hit <= 1'b0;
        else if (term_tick) berr_hit <= !berr_n;
    end

    // Latch the result on the way into S7.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
            err   <= 1'b0;
        end else if (s6_end) begin
            rdata <= (berr_hit || wr_q) ? '0 : d_in;
            err   <= berr_hit;
        end
    end

    // Completion pulse, one clock after the enable that ends S7.
    always_ff @(posedge clk) begin
        if (!rst_n) done <= 1'b0;
        else        done <= s7_end;
    end

endmodule

// File: rtl/abus_seq_drive.sv
// Pin decode: turns the current state and latched request into the strobe,
// direction and drive-enable levels of the external bus.
// Assumes the state register is the only source of timing.
module abus_seq_drive
    import abus_seq_pkg::*;
(
    input  phase_t phase,
    input  logic   wr_q,
    input  logic   ub_q,
    input  logic   lb_q,
    output logic   as_n,
    output logic   uds_n,
    output logic   lds_n,
    output logic   rw_n,
    output logic   a_oe,
    output logic   d_oe
);

    logic as_on;
    logic ds_on;
    logic addr_on;
    logic wr_span;

    // Group states into the windows each pin is active in.
    always_comb begin
        as_on   = phase inside {PH_S2, PH_S3, PH_S4, PH_W1, PH_W2, PH_S5, PH_S6};
        addr_on = as_on || (phase == PH_S1);
        wr_span = phase inside {PH_S3, PH_S4, PH_W1, PH_W2, PH_S5, PH_S6, PH_S7};
        ds_on   = wr_q ? (as_on && (phase != PH_S2)) : as_on;
    end

    // Map the windows onto the active-low pins.
    always_comb begin
        as_n  = !as_on;
        uds_n = !(ds_on && ub_q);
        lds_n = !(ds_on && lb_q);
        rw_n  = !(wr_q && wr_span);
        d_oe  = wr_q && wr_span;
        a_oe  = addr_on;
    end

endmodule

// File: rtl/abus_cycle_seq.sv
// Top level of the asynchronous bus cycle sequencer: joins the state walker,
// the holding registers and the pin decode. Terminations are expected to be
// synchronous to clk; the enable runs at twice the processor clock rate.
module abus_cycle_seq
    import abus_seq_pkg::*;
#(
    parameter int AW  = 23,
    parameter int DW  = 16,
    parameter int FCW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           st_en,
    input  logic           req_valid,
    input  logic           req_wr,
    input  logic           req_ub,
    input  logic           req_lb,
    input  logic [AW-1:0]  req_addr,
    input  logic [FCW-1:0] req_fc,
    input  logic [DW-1:0]  req_wdata,
    output logic           req_ready,
    output logic           done,
    output logic [DW-1:0]  rdata,
    output logic           err,
    output logic [AW-1:0]  a_out,
    output logic           a_oe,
    output logic [FCW-1:0] fc_out,
    output logic           rw_n,
    output logic           as_n,
    output logic           uds_n,
    output logic           lds_n,
    output logic [DW-1:0]  d_out,
    output logic           d_oe,
    input  logic [DW-1:0]  d_in,
    input  logic           dtack_n,
    input  logic           berr_n
);

    phase_t          phase;
    logic            accept;
    logic            term_tick;
    logic            s6_end;
    logic            s7_end;
    logic            wr_q;
    logic            ub_q;
    logic            lb_q;
    logic [AW-1:0]   addr_q;
    logic [FCW-1:0]  fc_q;
    logic [DW-1:0]   wdata_q;

    abus_seq_phase u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .st_en     (st_en),
        .req_valid (req_valid),
        .dtack_n   (dtack_n),
        .berr_n    (berr_n),
        .phase     (phase),
        .accept    (accept),
        .term_tick (term_tick),
        .s6_end    (s6_end),
        .s7_end    (s7_end)
    );

    abus_seq_capture #(.AW(AW), .DW(DW), .FCW(FCW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .term_tick (term_tick),
        .s6_end    (s6_end),
        .s7_end    (s7_end),
        .req_wr    (req_wr),
        .req_ub    (req_ub),
        .req_lb    (req_lb),
        .req_addr  (req_addr),
        .req_fc    (req_fc),
        .req_wdata (req_wdata),
        .d_in      (d_in),
        .berr_n    (berr_n),
        .wr_q      (wr_q),
        .ub_q      (ub_q),
        .lb_q      (lb_q),
        .addr_q    (addr_q),
        .fc_q      (fc_q),
        .wdata_q   (wdata_q),
        .rdata     (rdata),
        .err       (err),
        .done      (done)
    );

    abus_seq_drive u_drv (
        .phase (phase),
        .wr_q  (wr_q),
        .ub_q  (ub_q),
        .lb_q  (lb_q),
        .as_n  (as_n),
        .uds_n (uds_n),
        .lds_n (lds_n),
        .rw_n  (rw_n),
        .a_oe  (a_oe),
        .d_oe  (d_oe)
    );

    // Bus values come straight from the holding registers.
    always_comb begin
        req_ready = (phase == PH_IDLE);
        a_out     = addr_q;
        fc_out    = fc_q;
        d_out     = wdata_q;
    end

endmodule

// File: rtl/abus_cycle_seq_chk.sv
// Checker for the bus cycle sequencer: pin relations that must hold in
// every clock after reset. Attached to the top by the bind below.
module abus_cycle_seq_chk #(
    parameter int AW  = 23,
    parameter int FCW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic           req_ready,
    input logic           done,
    input logic           as_n,
    input logic           uds_n,
    input logic           lds_n,
    input logic           rw_n,
    input logic           a_oe,
    input logic           d_oe,
    input logic [AW-1:0]  a_out,
    input logic [FCW-1:0] fc_out
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (as_n && uds_n && lds_n && !a_oe && !d_oe)); // R2

    AST_ADDR_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && $past(a_oe)) |-> $stable(a_out)); // R3

    AST_FC_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && $past(!as_n)) |-> $stable(fc_out)); // R3

    AST_DS_UNDER_AS: assert property (@(posedge clk) disable iff (!rst_n)
        (!uds_n || !lds_n) |-> !as_n); // R4

    AST_WDATA_DIR: assert property (@(posedge clk) disable iff (!rst_n)
        d_oe |-> !rw_n); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

endmodule

bind abus_cycle_seq abus_cycle_seq_chk #(.AW(AW), .FCW(FCW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .as_n      (as_n),
    .uds_n     (uds_n),
    .lds_n     (lds_n),
    .rw_n      (rw_n),
    .a_oe      (a_oe),
    .d_oe      (d_oe),
    .a_out     (a_out),
    .fc_out    (fc_out)
);

// File: tb/abus_cycle_seq_tb.sv
// Bench for the bus cycle sequencer: a vector table of cycles checked state
// by state, then directed tests for reset, busy requests and a slow enable.
module abus_cycle_seq_tb;

    localparam int AW  = 23;
    localparam int DW  = 16;
    localparam int FCW = 3;
    localparam int NV  = 7;

    typedef struct packed {
        logic           wr;
        logic           ub;
        logic           lb;
        logic [AW-1:0]  addr;
        logic [DW-1:0]  wdata;
        logic [FCW-1:0] fc;
        logic [DW-1:0]  resp;
        logic [3:0]     nwait;
        logic           berr;
        logic           both;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{1'b0, 1'b1, 1'b1, 23'h012345, 16'h0000, 3'd5, 16'hBEEF, 4'd0, 1'b0, 1'b0},
        '{1'b1, 1'b1, 1'b1, 23'h7ABCDE, 16'hC0DE, 3'd1, 16'h0000, 4'd0, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b0, 23'h000100, 16'h0000, 3'd6, 16'h5A5A, 4'd2, 1'b0, 1'b0},
        '{1'b1, 1'b0, 1'b1, 23'h3FFFFF, 16'h00A5, 3'd2, 16'h0000, 4'd1, 1'b0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 23'h055555, 16'h0000, 3'd5, 16'h1234, 4'd1, 1'b1, 1'b0},
        '{1'b0, 1'b0, 1'b1, 23'h2AAAAA, 16'h0000, 3'd1, 16'h9876, 4'd0, 1'b0, 1'b1},
        '{1'b1, 1'b1, 1'b1, 23'h000002, 16'hFFFF, 3'd7, 16'h0000, 4'd3, 1'b1, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           st_en = 1'b1;
    logic           req_valid = 1'b0;
    logic           req_wr = 1'b0;
    logic           req_ub = 1'b0;
    logic           req_lb = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [FCW-1:0] req_fc = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_ready;
    logic           done;
    logic [DW-1:0]  rdata;
    logic           err;
    logic [AW-1:0]  a_out;
    logic           a_oe;
    logic [FCW-1:0] fc_out;
    logic           rw_n;
    logic           as_n;
    logic           uds_n;
    logic           lds_n;
    logic [DW-1:0]  d_out;
    logic           d_oe;
    logic [DW-1:0]  d_in = '0;
    logic           dtack_n = 1'b1;
    logic           berr_n = 1'b1;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    abus_cycle_seq #(.AW(AW), .DW(DW), .FCW(FCW)) u_dut (
        .clk(clk), .rst_n(rst_n), .st_en(st_en),
        .req_valid(req_valid), .req_wr(req_wr), .req_ub(req_ub), .req_lb(req_lb),
        .req_addr(req_addr), .req_fc(req_fc), .req_wdata(req_wdata),
        .req_ready(req_ready), .done(done), .rdata(rdata), .err(err),
        .a_out(a_out), .a_oe(a_oe), .fc_out(fc_out), .rw_n(rw_n),
        .as_n(as_n), .uds_n(uds_n), .lds_n(lds_n),
        .d_out(d_out), .d_oe(d_oe), .d_in(d_in),
        .dtack_n(dtack_n), .berr_n(berr_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One table cycle with the enable high on every clock; called at a negedge.
    task automatic run_vec(input vec_t v);
        int nst;
        int dec;
        logic [5:0] pins;
        nst = 8 + 2 * int'(v.nwait);
        dec = 4 + 2 * int'(v.nwait);
        req_wr = v.wr; req_ub = v.ub; req_lb = v.lb;
        req_addr = v.addr; req_fc = v.fc; req_wdata = v.wdata;
        req_valid = 1'b1;
        check("R2 ready before accept", req_ready, 1);
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < nst; k++) begin
            int  s;
            bit  as_on, ds_on, aon, wsp;
            if (k <= 4)        s = k;
            else if (k < dec + 1) s = 8;
            else               s = k - dec + 4;
            as_on = ((s >= 2) && (s <= 6)) || (s == 8);
            ds_on = v.wr ? (as_on && (s != 2)) : as_on;
            aon   = ((s >= 1) && (s <= 6)) || (s == 8);
            wsp   = ((s >= 3) && (s <= 7)) || (s == 8);
            pins  = {!as_on, !(ds_on && v.ub), !(ds_on && v.lb),
                     !(v.wr && wsp), aon, v.wr && wsp};
            check(v.wr ? "R5 write pins" : "R4 read pins",
                  {as_n, uds_n, lds_n, rw_n, a_oe, d_oe}, pins);
            check("R2 ready low in cycle", req_ready, 0);
            if (aon) check("R3 address", a_out, v.addr);
            if (s == 0) check("R3 fc and rw in S0", {fc_out, rw_n}, {v.fc, 1'b1});
            if (v.wr && wsp) check("R5 write data", d_out, v.wdata);
            if (s == 7 && !v.wr) check(v.berr || v.both ? "R9 rdata" : "R8 rdata", rdata,
                                       (v.berr || v.both) ? 0 : v.resp);
            if (s == 7) check(v.berr || v.both ? "R9 err" : "R8 err", err, v.berr || v.both);
            if (k == dec) begin
                dtack_n = v.berr && !v.both;
                berr_n  = !(v.berr || v.both);
            end
            if (s == 6) d_in = v.resp;
            if (s == 7) begin
                dtack_n = 1'b1; berr_n = 1'b1; d_in = '0;
            end
            @(posedge clk); @(negedge clk);
        end
        check(v.nwait == 0 ? "R6 done after 8 states" : "R7 done after waits", done, 1);
        check("R2 ready after cycle", req_ready, 1);
        @(posedge clk); @(negedge clk);
        check("R10 done one clock", done, 0);
    endtask

    // Watchdog.
    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset pins", {as_n, uds_n, lds_n, rw_n, a_oe, d_oe, done, req_ready},
              8'b1111_0001);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1 after reset", {as_n, uds_n, lds_n, rw_n, a_oe, d_oe, done, req_ready},
              8'b1111_0001);

        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R2: a request held valid during a busy cycle is not taken.
        begin
            int cnt;
            bit addr_ok;
            req_wr = 1'b0; req_ub = 1'b1; req_lb = 1'b1;
            req_addr = 23'h111111; req_fc = 3'd5; req_valid = 1'b1;
            dtack_n = 1'b0;
            @(posedge clk); @(negedge clk);
            req_addr = 23'h222222;
            cnt = 1; addr_ok = 1'b1;
            while (!done && cnt < 40) begin
                if (a_oe && a_out !== 23'h111111) addr_ok = 1'b0;
                @(posedge clk); @(negedge clk);
                cnt++;
            end
            check("R2 busy request leaves address", addr_ok, 1);
            check("R2 R6 accept to done clocks", cnt, 9);
            @(posedge clk); @(negedge clk);
            check("R2 held request taken when idle", req_ready, 0);
            req_valid = 1'b0;
            @(posedge clk); @(negedge clk);
            check("R2 second cycle address", a_out, 23'h222222);
            while (!done) begin @(posedge clk); @(negedge clk); end
            dtack_n = 1'b1;
            @(posedge clk); @(negedge clk);
        end

        // R10: enable every third clock stretches each state.
        begin
            int first_as, n_as, done_at;
            first_as = -1; n_as = 0; done_at = -1;
            dtack_n = 1'b0;
            req_wr = 1'b0; req_ub = 1'b1; req_lb = 1'b0; req_addr = 23'h000777;
            for (int c = 0; c < 30; c++) begin
                st_en = (c % 3 == 0);
                req_valid = (c == 0);
                @(posedge clk); @(negedge clk);
                if (!as_n) begin
                    n_as++;
                    if (first_as < 0) first_as = c + 1;
                end
                if (done && done_at < 0) done_at = c + 1;
            end
            check("R10 strobe start with slow enable", first_as, 7);
            check("R10 strobe length with slow enable", n_as, 15);
            check("R10 done with slow enable", done_at, 25);
            st_en = 1'b1; dtack_n = 1'b1;
        end

        // R1: reset in the middle of a cycle returns the pins to idle.
        req_valid = 1'b1; req_wr = 1'b1;
        repeat (4) begin @(posedge clk); @(negedge clk); end
        req_valid = 1'b0;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R1 mid-cycle reset", {as_n, uds_n, lds_n, rw_n, a_oe, d_oe, done, req_ready},
              8'b1111_0001);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule